// File: doc/BRIEF.md
# Transaction-Aware Warp Reconvergence Stack

This block keeps the control-flow state of one warp in a SIMT core. Its output is the program counter the warp fetches from next and the mask of lanes that execute that instruction. The core's issue logic reports one control event per cycle: a sequential step, a branch with per-lane outcomes and a reconvergence point, the start of a transactional region, or a commit carrying the per-lane validation failures. A divergent branch runs the taken lanes first and the fall-through lanes next. The full mask returns at the reconvergence point.

A transactional region pushes a special entry that stores the region's start address. At commit, the lanes that failed validation become that entry's lane set, and the body runs again from the start address for those lanes only. Lanes that committed stay masked off until the whole warp has committed. The special entry is then removed, and the warp continues at the commit continuation with the lane set it had at region entry.

The design assumes two things: a divergent branch's reconvergence address differs from both of its path start addresses, and a commit continuation is never a reconvergence point.

Top module: `simt_tx_stack`

## Requirements
- R1: After reset, `pc_o` equals RESET_PC (0x0100 by default), `mask_o` has every lane set, and both error flags are low.
- R2: `op_i` encodes 0 idle, 1 step, 2 branch, 3 transaction begin, 4 commit. Idle changes nothing. A step loads `next_pc_i` into the current PC and keeps the mask.
- R3: A branch where every active lane has the same `taken_i` value pushes nothing and keeps the mask. The PC becomes `tgt_pc_i` when all active lanes are taken and `next_pc_i` when none are. `taken_i` bits of inactive lanes are ignored.
- R4: A divergent branch makes the taken active lanes current at `tgt_pc_i`. The not-taken active lanes wait at `next_pc_i`, and both paths record `rpc_i`.
- R5: When a path's next PC (from a step or a uniform branch) equals its recorded reconvergence address, the path is dropped. The waiting sibling path resumes; once both are done, the full pre-branch mask resumes at the reconvergence address.
- R6: Transaction begin sets the PC to `tgt_pc_i` (the region start) and keeps the mask.
- R7: A commit on a transaction entry with failing lanes (`abort_i` AND current mask, non-zero) restarts at the region start with only those lanes active. `abort_i` bits of inactive lanes are ignored.
- R8: A commit with no failing lanes removes the transaction entry. The PC becomes `next_pc_i`, and the mask becomes the one held at transaction begin.
- R9: `mask_o` is never all zeros.
- R10: An event needing more entries than are free is ignored, and `ovf_o` pulses high for one cycle. A divergent branch needs two entries, or one when the current entry is a path with the same reconvergence address. A transaction begin needs one. The stack holds DEPTH (8) entries, one of them the base.
- R11: A commit when the current entry is not a transaction entry is ignored, and `bad_pop_o` pulses high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Control event code |
| next_pc_i | input | PCW | Step target, branch fall-through, or commit continuation |
| tgt_pc_i | input | PCW | Branch target or transaction region start |
| rpc_i | input | PCW | Reconvergence address of a branch |
| taken_i | input | LANES | Per-lane branch outcome |
| abort_i | input | LANES | Per-lane validation failure at commit |
| pc_o | output | PCW | Current warp PC |
| mask_o | output | LANES | Current active lane mask |
| ovf_o | output | 1 | Event rejected because the stack is full |
| bad_pop_o | output | 1 | Commit rejected because no transaction entry is current |

## Verification
The hardest states to reach are the two partial-capacity overflows. One is a divergent branch with exactly one free entry. The other is a divergence whose top is a transaction entry that must take the reconvergence address. The stimulus stacks seven nested transaction begins to fill the stack and provokes a rejected begin. It then commits one level so that a single entry is free, which makes a divergent branch overflow. After committing one more level, the same branch fits, and both of its paths unwind onto the transaction entry. The retry loop is driven through two rounds of shrinking failure sets, with abort bits on lanes that are already inactive.

// File: rtl/txs_pkg.sv
// Package txs_pkg
// Shared encodings for the warp reconvergence stack.
// Assumes a single control event per cycle presented on op_i.
package txs_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_STEP   = 3'd1,
        OP_BRANCH = 3'd2,
        OP_TBEGIN = 3'd3,
        OP_COMMIT = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ENT_BASE = 2'd0,
        ENT_PATH = 2'd1,
        ENT_TXN  = 2'd2
    } ent_kind_e;

endpackage

// File: rtl/txs_split.sv
// Module txs_split
// Splits the current active mask by a per-lane branch outcome.
// Assumes active_i is non-zero; outcome bits of idle lanes are dropped.
module txs_split #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] active_i,
    input  logic [LANES-1:0] taken_i,
    output logic [LANES-1:0] tk_o,
    output logic [LANES-1:0] nt_o,
    output logic             uniform_o,
    output logic             all_tk_o
);
    // Partition the active lanes and classify the branch.
    always_comb begin
        tk_o      = active_i & taken_i;
        nt_o      = active_i & ~taken_i;
        uniform_o = (tk_o == '0) || (nt_o == '0);
        all_tk_o  = (nt_o == '0);
    end
endmodule

// File: rtl/txs_commit.sv
// Module txs_commit
// Decides the outcome of a transaction commit from validation results.
// Assumes active_i is the lane set of the current transaction entry.
module txs_commit #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] active_i,
    input  logic [LANES-1:0] abort_i,
    output logic [LANES-1:0] fail_o,
    output logic             retry_o
);
    // Failing lanes are those still active that did not validate.
    always_comb begin
        fail_o  = active_i & abort_i;
        retry_o = |fail_o;
    end
endmodule

// File: rtl/simt_tx_stack.sv
// Module simt_tx_stack
// Per-warp reconvergence stack with transaction retry entries.
// The top entry supplies the warp PC and active mask. Path entries carry a
// reconvergence address; transaction entries carry the region start.
// Assumes a branch's reconvergence address differs from both path starts
// and that a commit continuation is not a reconvergence point.
module simt_tx_stack
    import txs_pkg::*;
#(
    parameter int              LANES    = 8,
    parameter int              PCW      = 16,
    parameter int              DEPTH    = 8,
    parameter logic [PCW-1:0]  RESET_PC = 'h0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [PCW-1:0]   next_pc_i,
    input  logic [PCW-1:0]   tgt_pc_i,
    input  logic [PCW-1:0]   rpc_i,
    input  logic [LANES-1:0] taken_i,
    input  logic [LANES-1:0] abort_i,
    output logic [PCW-1:0]   pc_o,
    output logic [LANES-1:0] mask_o,
    output logic             ovf_o,
    output logic             bad_pop_o
);
    localparam int SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int TOP = DEPTH - 1;

    typedef struct packed {
        ent_kind_e        kind;
        logic [PCW-1:0]   pc;
        logic [PCW-1:0]   rpc;
        logic [PCW-1:0]   spc;
        logic [LANES-1:0] mask;
    } entry_t;

    entry_t           stk_q [DEPTH];
    logic [SPW-1:0]   sp_q;
    logic             ovf_q, bad_q;
    entry_t           top_e;
    op_e              op;
    logic             top_is_txn, top_is_path;
    logic [LANES-1:0] tk_mask, nt_mask, fail_mask;
    logic             br_uniform, br_all_tk, cm_retry;
    logic [PCW-1:0]   seq_pc;
    logic             reconv_hit, share_slot, div_fits, push_fits;
    logic [SPW-1:0]   div_base;

    // Current entry and event decode.
    always_comb begin
        top_e       = stk_q[sp_q];
        op          = op_e'(op_i);
        top_is_txn  = (top_e.kind == ENT_TXN);
        top_is_path = (top_e.kind == ENT_PATH);
    end

    txs_split #(.LANES(LANES)) u_split (
        .active_i  (top_e.mask),
        .taken_i   (taken_i),
        .tk_o      (tk_mask),
        .nt_o      (nt_mask),
        .uniform_o (br_uniform),
        .all_tk_o  (br_all_tk)
    );

    txs_commit #(.LANES(LANES)) u_commit (
        .active_i (top_e.mask),
        .abort_i  (abort_i),
        .fail_o   (fail_mask),
        .retry_o  (cm_retry)
    );

    // Sequential target, reconvergence test and capacity checks.
    always_comb begin
        seq_pc     = (op == OP_BRANCH && br_all_tk) ? tgt_pc_i : next_pc_i;
        reconv_hit = top_is_path && (seq_pc == top_e.rpc);
        share_slot = top_is_path && (top_e.rpc == rpc_i);
        div_fits   = (int'(sp_q) + (share_slot ? 1 : 2)) <= TOP;
        push_fits  = int'(sp_q) < TOP;
        div_base   = share_slot ? sp_q : sp_q + SPW'(1);
    end

    // Stack state update, one control event per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
            stk_q[0].kind <= ENT_BASE;
            stk_q[0].pc   <= RESET_PC;
            stk_q[0].mask <= '1;
            sp_q  <= '0;
            ovf_q <= 1'b0;
            bad_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            bad_q <= 1'b0;
            case (op)
                OP_STEP, OP_BRANCH: begin
                    if (op == OP_STEP || br_uniform) begin
                        if (reconv_hit) sp_q <= sp_q - SPW'(1);
                        else            stk_q[sp_q].pc <= seq_pc;
                    end else if (!div_fits) begin
                        ovf_q <= 1'b1;
                    end else begin
                        if (!share_slot) stk_q[sp_q].pc <= rpc_i;
                        stk_q[div_base] <= '{kind: ENT_PATH, pc: next_pc_i,
                                             rpc: rpc_i, spc: '0, mask: nt_mask};
                        stk_q[div_base + SPW'(1)] <= '{kind: ENT_PATH, pc: tgt_pc_i,
                                             rpc: rpc_i, spc: '0, mask: tk_mask};
                        sp_q <= div_base + SPW'(1);
                    end
                end
                OP_TBEGIN: begin
                    if (!push_fits) begin
                        ovf_q <= 1'b1;
                    end else begin
                        stk_q[sp_q + SPW'(1)] <= '{kind: ENT_TXN, pc: tgt_pc_i,
                                             rpc: '0, spc: tgt_pc_i, mask: top_e.mask};
                        sp_q <= sp_q + SPW'(1);
                    end
                end
                OP_COMMIT: begin
                    if (!top_is_txn) begin
                        bad_q <= 1'b1;
                    end else if (cm_retry) begin
                        stk_q[sp_q].mask <= fail_mask;
                        stk_q[sp_q].pc   <= top_e.spc;
                    end else begin
                        stk_q[sp_q - SPW'(1)].pc <= next_pc_i;
                        sp_q <= sp_q - SPW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Drive outputs from the current entry and the error registers.
    always_comb begin
        pc_o      = top_e.pc;
        mask_o    = top_e.mask;
        ovf_o     = ovf_q;
        bad_pop_o = bad_q;
    end
endmodule

// File: rtl/simt_tx_stack_chk.sv
// Module simt_tx_stack_chk
// Property checker for simt_tx_stack, attached with bind below.
// Assumes op codes as in txs_pkg.
module simt_tx_stack_chk
    import txs_pkg::*;
#(
    parameter int LANES = 8,
    parameter int PCW   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_i,
    input logic [PCW-1:0]   tgt_pc_i,
    input logic [LANES-1:0] taken_i,
    input logic [LANES-1:0] abort_i,
    input logic [PCW-1:0]   pc_o,
    input logic [LANES-1:0] mask_o,
    input logic             ovf_o,
    input logic             bad_pop_o,
    input logic             top_txn
);
    // R9
    mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_o != '0);

    // R4
    diverge_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_BRANCH && (taken_i & mask_o) != '0 && (taken_i & mask_o) != mask_o)
        |=> (ovf_o || mask_o == $past(taken_i & mask_o)));

    // R6
    tbegin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_TBEGIN)
        |=> (ovf_o || (mask_o == $past(mask_o) && pc_o == $past(tgt_pc_i))));

    // R7
    retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_COMMIT && top_txn && (abort_i & mask_o) != '0)
        |=> (mask_o == $past(abort_i & mask_o)));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (pc_o == $past(pc_o) && mask_o == $past(mask_o)));

    // R11
    bad_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_pop_o |-> ($past(op_i) == OP_COMMIT && pc_o == $past(pc_o)
                       && mask_o == $past(mask_o)));
endmodule

bind simt_tx_stack simt_tx_stack_chk #(.LANES(LANES), .PCW(PCW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .tgt_pc_i  (tgt_pc_i),
    .taken_i   (taken_i),
    .abort_i   (abort_i),
    .pc_o      (pc_o),
    .mask_o    (mask_o),
    .ovf_o     (ovf_o),
    .bad_pop_o (bad_pop_o),
    .top_txn   (top_is_txn)
);

// File: tb/simt_tx_stack_tb_top.sv
// Scoreboard bench: the driver queues the expected state for each event,
// and the monitor compares it one time unit after the capturing edge.
module simt_tx_stack_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [15:0] next_pc_i = '0, tgt_pc_i = '0, rpc_i = '0;
    logic [7:0]  taken_i = '0, abort_i = '0;
    logic [15:0] pc_o;
    logic [7:0]  mask_o;
    logic        ovf_o, bad_pop_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] pc;
        logic [7:0]  mask;
        logic        ovf;
        logic        bad;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    simt_tx_stack dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .next_pc_i(next_pc_i),
        .tgt_pc_i(tgt_pc_i), .rpc_i(rpc_i), .taken_i(taken_i), .abort_i(abort_i),
        .pc_o(pc_o), .mask_o(mask_o), .ovf_o(ovf_o), .bad_pop_o(bad_pop_o)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (pc_o !== e.pc || mask_o !== e.mask || ovf_o !== e.ovf || bad_pop_o !== e.bad) begin
            errors++;
            $display("FAIL %s: actual pc=%h mask=%h ovf=%b bad=%b expected pc=%h mask=%h ovf=%b bad=%b",
                     e.tag, pc_o, mask_o, ovf_o, bad_pop_o, e.pc, e.mask, e.ovf, e.bad);
        end
    endtask

    task automatic ev(input logic [2:0] op, input logic [15:0] nxt, input logic [15:0] tgt,
                      input logic [15:0] rpc, input logic [7:0] tk, input logic [7:0] ab,
                      input logic [15:0] epc, input logic [7:0] emask,
                      input logic eovf, input logic ebad, input string tag);
        exp_t e;
        @(negedge clk);
        op_i = op; next_pc_i = nxt; tgt_pc_i = tgt; rpc_i = rpc; taken_i = tk; abort_i = ab;
        e.pc = epc; e.mask = emask; e.ovf = eovf; e.bad = ebad; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare after each capturing edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all R): actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        r.pc = 16'h0100; r.mask = 8'hFF; r.ovf = 1'b0; r.bad = 1'b0; r.tag = "R1 reset";
        compare(r);

        ev(0, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0100, 8'hFF, 0, 0, "R2 idle");
        ev(1, 16'h0104, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0104, 8'hFF, 0, 0, "R2 step");
        ev(2, 16'h0108, 16'h0200, 16'h0300, 8'hFF, 8'h00, 16'h0200, 8'hFF, 0, 0, "R3 all taken");
        ev(2, 16'h0204, 16'h0400, 16'h0300, 8'h00, 8'h00, 16'h0204, 8'hFF, 0, 0, "R3 none taken");
        ev(2, 16'h0208, 16'h0210, 16'h0230, 8'h0F, 8'h00, 16'h0210, 8'h0F, 0, 0, "R4 diverge");
        ev(1, 16'h0214, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0214, 8'h0F, 0, 0, "R4 taken path");
        ev(1, 16'h0230, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0208, 8'hF0, 0, 0, "R5 sibling");
        ev(2, 16'h020C, 16'h0220, 16'h0230, 8'h3F, 8'h00, 16'h0220, 8'h30, 0, 0, "R4 nested");
        ev(1, 16'h0230, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h020C, 8'hC0, 0, 0, "R5 nested sibling");
        ev(1, 16'h0230, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0230, 8'hFF, 0, 0, "R5 full mask");
        ev(3, 16'h0000, 16'h0500, 16'h0000, 8'h00, 8'h00, 16'h0500, 8'hFF, 0, 0, "R6 begin");
        ev(1, 16'h0504, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0504, 8'hFF, 0, 0, "R2 body");
        ev(4, 16'h0510, 16'h0000, 16'h0000, 8'h00, 8'h05, 16'h0500, 8'h05, 0, 0, "R7 retry");
        ev(1, 16'h0504, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0504, 8'h05, 0, 0, "R7 retry body");
        ev(4, 16'h0510, 16'h0000, 16'h0000, 8'h00, 8'hF1, 16'h0500, 8'h01, 0, 0, "R7 masked abort");
        ev(4, 16'h0510, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0510, 8'hFF, 0, 0, "R8 exit");
        ev(4, 16'h0520, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0510, 8'hFF, 0, 1, "R11 stray commit");
        ev(0, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0510, 8'hFF, 0, 0, "R11 pulse ends");
        for (int i = 0; i < 7; i++) begin
            ev(3, 16'h0000, 16'h0600 + 16'(i * 16), 16'h0000, 8'h00, 8'h00,
               16'h0600 + 16'(i * 16), 8'hFF, 0, 0, "R6 nest");
        end
        ev(3, 16'h0000, 16'h0670, 16'h0000, 8'h00, 8'h00, 16'h0660, 8'hFF, 1, 0, "R10 full begin");
        ev(4, 16'h0700, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0700, 8'hFF, 0, 0, "R8 unwind");
        ev(2, 16'h0724, 16'h0720, 16'h0740, 8'h0F, 8'h00, 16'h0700, 8'hFF, 1, 0, "R10 one free");
        ev(4, 16'h0710, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0710, 8'hFF, 0, 0, "R8 unwind");
        ev(2, 16'h0724, 16'h0720, 16'h0740, 8'h0F, 8'h00, 16'h0720, 8'h0F, 0, 0, "R4 fits");
        ev(4, 16'h0999, 16'h0000, 16'h0000, 8'h00, 8'hFF, 16'h0720, 8'h0F, 0, 1, "R11 commit on path");
        ev(1, 16'h0740, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0724, 8'hF0, 0, 0, "R5 sibling in tx");
        ev(1, 16'h0740, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0740, 8'hFF, 0, 0, "R5 tx entry resumes");
        ev(4, 16'h0750, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0750, 8'hFF, 0, 0, "R8 restore");
        ev(0, 16'h0000, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0750, 8'hFF, 0, 0, "R9 idle tail");

        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule